// File: doc/BRIEF.md
# Two-Wire Pin Control Register

This block lets software drive the clock and data wires of a two-wire serial bus directly. Software gives each wire a level by writing to two separate words: a set word and a clear word. Only the written bits change, so no read-modify-write is needed. The wires are open-drain. A latch bit of 0 pulls its wire low. A latch bit of 1 releases the wire, and an external pull-up brings it high.

One status word reports two things: the clock bit as software last commanded it, and the data wire as actually sensed. The sensed data level passes through a synchronizer, so software can read acknowledge bits and data from a target device. All protocol sequencing stays in software. The block decodes a 4 KB window on a simple slave bus with one-cycle registered reads. Any offset it does not decode reads as all ones.

Top module: `i2c_pin_regs`

## Requirements
- R1: On reset the pin latch is 2'b11, so both wires are released (`scl_oe` = 0, `sda_oe` = 0). A read of offset 0x000 with the data wire high then returns 0x3.
- R2: A write to offset 0x000 ORs write-data bits [1:0] into the latch. Bit 0 is the clock wire and bit 1 is the data wire.
- R3: A write to offset 0x004 clears each latch bit whose write-data bit is 1 and leaves the other latch bit unchanged.
- R4: A read of offset 0x000 returns latch bit 0 in bit 0 and the synchronized data-wire level in bit 1. Bits [31:2] read as 0. The data appears in `bus_rdata` one clock after the read is presented.
- R5: A read of any offset other than 0x000, including 0x004, returns 0xFFFFFFFF.
- R6: A write to any offset other than 0x000 and 0x004 leaves the latch unchanged.
- R7: The wires are open-drain. `scl_oe` is the inverse of latch bit 0 and `sda_oe` is the inverse of latch bit 1. Asserting an output enable means pulling that wire low.
- R8: After a write, the clock wire takes its new latch value one clock after the latch updates, and the data wire takes its value one clock after that. The clock wire therefore always changes first.
- R9: The `sda_in` level passes through a two-flop synchronizer. A change on `sda_in` is visible to a read presented two clocks later or after.
- R10: A read has no effect on the latch or on the wires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_wdata | input | 2 | Write data (pin bits only) |
| bus_rdata | output | 32 | Registered read data |
| scl_oe | output | 1 | Clock wire pull-low enable |
| sda_oe | output | 1 | Data wire pull-low enable |
| sda_in | input | 1 | Sensed level of the data wire |

## Verification
A wrong latch bit shows up in two places. It appears in bit 0 of the next status read, and it appears on the output enables two or three clocks after the write that caused it. A set or clear that touches the wrong bit therefore shows within a few clocks. A bad decode shows directly in the read data or as a latch that changes when it should not. A synchronizer that is too short or too long moves the point at which a new `sda_in` level first appears in a read. The bench checks this by reading before and after the two-clock window.

// File: rtl/i2c_pin_pkg.sv
package i2c_pin_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int NPINS    = 2;
  localparam int SYNC_LEN = 2;
  localparam int PIN_SCL  = 0;
  localparam int PIN_SDA  = 1;
  localparam logic [ADDR_W-1:0] OFF_SET = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CLR = 12'h004;
  localparam logic [NPINS-1:0]  LATCH_RST = '1;
endpackage

// File: rtl/i2c_pin_latch.sv
module i2c_pin_latch
  import i2c_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic              rd_en,
  input  logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= LATCH_RST;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
  end

  AST_SET_ORS: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((q & $past(mask)) == $past(mask))); // R2
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((q & $past(mask)) == '0 && (q & ~$past(mask)) == ($past(q) & ~$past(mask)))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(q)); // R6
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !set_en && !clr_en) |=> $stable(q)); // R10
endmodule

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync
  import i2c_pin_pkg::*;
#(
  parameter int STAGES = SYNC_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;
  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else begin
      sr[0] <= din;
      for (int k = 1; k < STAGES; k++) sr[k] <= sr[k-1];
    end
  end
  assign dout = sr[STAGES-1];
endmodule

// File: rtl/i2c_pin_drive.sv
module i2c_pin_drive
  import i2c_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lat,
  output logic [NPINS-1:0] oe
);
  // Pin g follows its latch bit after g+1 clocks, so lower-numbered pins update first.
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [g:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else begin
        chain[0] <= ~lat[g];
        for (int k = 1; k <= g; k++) chain[k] <= chain[k-1];
      end
    end
    assign oe[g] = chain[g];
  end

  AST_RST_RELEASED: assert property (@(posedge clk)
    $past(rst) |-> (oe == '0)); // R1
endmodule

// File: rtl/i2c_pin_regs.sv
module i2c_pin_regs
  import i2c_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic             hit_set, hit_clr, hit_stat;
  logic [NPINS-1:0] lat, oe;
  logic             sda_s;
  logic [DATA_W-1:0] rd_word;

  assign hit_set  = bus_wen && (bus_addr == OFF_SET);
  assign hit_clr  = bus_wen && (bus_addr == OFF_CLR);
  assign hit_stat = (bus_addr == OFF_SET);

  i2c_pin_latch u_latch (
    .clk(clk), .rst(rst), .set_en(hit_set), .clr_en(hit_clr),
    .rd_en(bus_ren), .mask(bus_wdata), .q(lat)
  );

  i2c_pin_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .din(sda_in), .dout(sda_s)
  );

  i2c_pin_drive u_drive (
    .clk(clk), .rst(rst), .lat(lat), .oe(oe)
  );

  assign scl_oe = oe[PIN_SCL];
  assign sda_oe = oe[PIN_SDA];

  always_comb begin
    rd_word = '1;
    if (hit_stat) begin
      rd_word = '0;
      rd_word[0] = lat[PIN_SCL];
      rd_word[1] = sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_word;
  end

  AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && bus_addr != OFF_SET) |=> (bus_rdata == '1)); // R5
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && bus_addr == OFF_SET) |=> (bus_rdata[DATA_W-1:2] == '0)); // R4
  AST_SCL_BIT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && bus_addr == OFF_SET) |=> (bus_rdata[0] == $past(lat[PIN_SCL]))); // R4
  AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr != OFF_SET && bus_addr != OFF_CLR) |=> $stable(lat)); // R6
endmodule

// File: tb/i2c_pin_regs_tb.sv
module i2c_pin_regs_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [11:0] bus_addr = '0;
  logic        bus_wen = 0, bus_ren = 0;
  logic [1:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        scl_oe, sda_oe;
  logic        sda_in = 1;

  int total = 0, bad = 0;
  logic [1:0] m_lat;
  bit done = 0;

  i2c_pin_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_in)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] exp_stat(logic [1:0] l, logic s);
    return {30'd0, s, l[0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [1:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1;
    @(negedge clk);
    bus_wen = 0;
    if (a == 12'h000) m_lat = m_lat | d;
    else if (a == 12'h004) m_lat = m_lat & ~d;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    bus_addr = a; bus_ren = 1;
    @(negedge clk);
    bus_ren = 0;
    v = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1c2d3e4f));
    m_lat = 2'b11;
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    chk("R1 scl_oe", {31'd0, scl_oe}, 0);
    chk("R1 sda_oe", {31'd0, sda_oe}, 0);
    rd(12'h000, v); chk("R1 status", v, 32'h3);

    // R7 R8 ordering: clear both, clock wire first
    wr(12'h004, 2'b11);
    idle(1);
    chk("R8 scl first", {30'd0, sda_oe, scl_oe}, 32'b01);
    idle(1);
    chk("R7 both low", {30'd0, sda_oe, scl_oe}, 32'b11);
    // R8 release both
    wr(12'h000, 2'b11);
    idle(1);
    chk("R8 scl release first", {30'd0, sda_oe, scl_oe}, 32'b10);
    idle(1);
    chk("R7 both released", {30'd0, sda_oe, scl_oe}, 32'b00);

    // R3 clear only data bit
    wr(12'h004, 2'b10); idle(2);
    chk("R3 clr sda only", {30'd0, sda_oe, scl_oe}, 32'b10);
    // R2 set data bit
    wr(12'h000, 2'b10); idle(2);
    chk("R2 set sda", {30'd0, sda_oe, scl_oe}, 32'b00);
    // R6 write to offset 0x008 ignored
    wr(12'h008, 2'b00);
    wr(12'hFFC, 2'b11); idle(2);
    chk("R6 bad write ignored", {30'd0, sda_oe, scl_oe}, 32'b00);

    // R5 bad read offsets
    rd(12'h004, v); chk("R5 read clr offset", v, 32'hFFFFFFFF);
    rd(12'hABC, v); chk("R5 read random offset", v, 32'hFFFFFFFF);

    // R9 synchronizer: sda_in low; at the next edge only stage 1 has it
    sda_in = 0;
    rd(12'h000, v); chk("R9 not yet visible", v, exp_stat(m_lat, 1));
    idle(1);
    rd(12'h000, v); chk("R9 visible after two", v, exp_stat(m_lat, 0));
    sda_in = 1; idle(3);

    // R10 read leaves wires alone
    wr(12'h004, 2'b01); idle(2);
    rd(12'h000, v); rd(12'h000, v); idle(2);
    chk("R10 wires after reads", {30'd0, sda_oe, scl_oe}, {30'd0, ~m_lat[1], ~m_lat[0]});
    chk("R4 status after clr", v, exp_stat(m_lat, 1));

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: wr(12'h000, 2'($urandom()));
        1: wr(12'h004, 2'($urandom()));
        2: begin
             logic [11:0] a;
             a = 12'($urandom());
             if (a == 12'h000 || a == 12'h004) a = 12'h010;
             wr(a, 2'($urandom()));
           end
        3: begin rd(12'h000, v); chk("R4 random status", v, exp_stat(m_lat, sda_in)); end
        4: begin
             logic [11:0] a;
             a = 12'($urandom());
             if (a == 12'h000) a = 12'h800;
             rd(a, v); chk("R5 random bad read", v, 32'hFFFFFFFF);
           end
        default: begin sda_in = 1'($urandom()); idle(2); end
      endcase
      if (it % 16 == 15) begin
        idle(2);
        chk("R7 random wires", {30'd0, sda_oe, scl_oe}, {30'd0, ~m_lat[1], ~m_lat[0]});
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule